// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a clocked host and an asynchronous static RAM of 512K words by 24 bits. The RAM is split into three 8-bit lanes. Each lane has its own active-low enable, and all lanes share one write strobe and one output enable. The host issues one single-beat request at a time over a valid/ready handshake. A request carries a word address, write data, a write flag and a 3-bit lane mask, where mask bit k selects data bits 8k+7..8k. Read data comes back on a separate bus, qualified by a one-cycle valid strobe.

All memory-side signals come from flops, so the waveforms are free of glitches. The timing of the RAM is met with cycle counts set by parameters: read access (`ACC_CYC`, default 2), write pulse (`WP_CYC`, 1), data setup (`DS_CYC`, 1) and bus turnaround (`TA_CYC`, 1). The write data phase lasts `DRV_CYC` = max(`DS_CYC`, `WP_CYC` − `TA_CYC`, 1) cycles, which is 1 with the defaults.

The controller has five states:
- `ST_IDLE`: ready is high and nothing on the memory side is asserted.
- `ST_RD_ACCESS`: the selected lanes are enabled with the output enable low, for `ACC_CYC` cycles.
- `ST_RD_RECOVER`: everything is released for `TA_CYC` cycles.
- `ST_WR_TURN`: the write strobe and the lane enables are low, with the bus not driven, for `TA_CYC` cycles.
- `ST_WR_DRIVE`: the write data is driven for `DRV_CYC` cycles.

The transitions are:
- IDLE→RD_ACCESS on an accepted read.
- IDLE→WR_TURN on an accepted write.
- RD_ACCESS→RD_RECOVER when the access count ends. Read data is captured on this transition.
- RD_RECOVER→IDLE when the turnaround count ends.
- WR_TURN→WR_DRIVE when the turnaround count ends.
- WR_DRIVE→IDLE when the drive count ends. The strobe, the enables and the drive are released on the same edge.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and right after synchronous reset, all lane enables, the write strobe and the output enable are high, bus drive is off, `req_ready` is high and `rsp_valid` is low.
- R2: Taking the acceptance edge as edge 0, a read holds the selected lane enables low (`mem_ce_n` = ~mask), `mem_oe_n` low and `mem_we_n` high for exactly `ACC_CYC` cycles.
- R3: `rsp_valid` pulses high for one cycle, in the cycle after the access ends (cycle `ACC_CYC`+1 after acceptance). Each lane of `rsp_rdata` whose mask bit is 1 carries the memory data sampled at the end of the access. Each lane whose mask bit is 0 reads zero.
- R4: After a read, all lane enables and the output enable stay high for `TA_CYC` cycles before `req_ready` returns, `ACC_CYC`+`TA_CYC` cycles after acceptance.
- R5: A write pulls `mem_we_n` low with the selected lane enables low. For the first `TA_CYC` cycles after the strobe falls, `mem_dq_oe` stays low.
- R6: After the turnaround, write data is driven for `DRV_CYC` cycles with the strobe still low. The strobe, the lane enables and the drive are then released together. `mem_addr` does not change while the strobe is low. `req_ready` returns `TA_CYC`+`DRV_CYC` cycles after acceptance.
- R7: A write changes only the memory lanes whose mask bit is 1.
- R8: `req_ready` is low from the edge after acceptance until the operation and its recovery end. A request held valid while the controller is busy has no effect.
- R9: A request with an all-zero mask asserts no lane enable, so the memory stays in standby. Such a read returns zero.
- R10: The controller drives the bus only while the write strobe is low and the output enable is high. It never drives while the memory may be driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | LANES*LANE_W | Write data |
| req_lanes | input | LANES | Lane mask; bit k selects bits 8k+7..8k |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | LANES*LANE_W | Read data; unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | LANES | Per-lane enables, active low |
| mem_we_n | output | 1 | Shared write strobe, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_out | output | LANES*LANE_W | Data to drive onto the bus |
| mem_dq_in | input | LANES*LANE_W | Data sampled from the bus |
| mem_dq_oe | output | 1 | Bus drive enable |

## Verification
A wrong state or a wrong count shows up at the ports within one operation. Either `req_ready` or `rsp_valid` arrives a cycle early or late, or a lane enable or the strobe stays asserted too long. The memory model in the bench catches either of these on the next read of the same word. A turnaround fault shows up as drive enabled in the cycle the strobe falls, or together with an active output enable, in that same cycle. A fault in a mask latch corrupts a neighbouring lane, and this appears as a data mismatch on a later read.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_RECOVER,
        ST_WR_TURN,
        ST_WR_DRIVE
    } ctl_state_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
    parameter int unsigned LANES  = 3,
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANES-1:0]        lanes,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign dout[l*LANE_W +: LANE_W] = lanes[l] ? din[l*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int unsigned ADDR_W  = 19,
    parameter int unsigned LANE_W  = 8,
    parameter int unsigned LANES   = 3,
    parameter int unsigned ACC_CYC = 2,
    parameter int unsigned WP_CYC  = 1,
    parameter int unsigned DS_CYC  = 1,
    parameter int unsigned TA_CYC  = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [LANES*LANE_W-1:0]   req_wdata,
    input  logic [LANES-1:0]          req_lanes,
    output logic                      rsp_valid,
    output logic [LANES*LANE_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [LANES-1:0]          mem_ce_n,
    output logic                      mem_we_n,
    output logic                      mem_oe_n,
    output logic [LANES*LANE_W-1:0]   mem_dq_out,
    input  logic [LANES*LANE_W-1:0]   mem_dq_in,
    output logic                      mem_dq_oe
);
    localparam int unsigned DATA_W  = LANES * LANE_W;
    localparam int unsigned WP_REM  = (WP_CYC > TA_CYC) ? (WP_CYC - TA_CYC) : 1;
    localparam int unsigned DRV_CYC = max2(DS_CYC, WP_REM);
    localparam int unsigned MAX_CYC = max2(max2(ACC_CYC, TA_CYC), DRV_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    ctl_state_t       state, state_nxt;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             accept, capture;
    logic [LANES-1:0] lat_lanes, lanes_use;
    logic [DATA_W-1:0] cap_data;

    sram_lane_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_lane_capture #(.LANES(LANES), .LANE_W(LANE_W)) capture_i (
        .lanes (lat_lanes),
        .din   (mem_dq_in),
        .dout  (cap_data)
    );

    // Next-state and timer load decode
    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        accept    = 1'b0;
        capture   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_nxt = ST_WR_TURN;
                        tmr_val   = CNT_W'(TA_CYC - 1);
                    end else begin
                        state_nxt = ST_RD_ACCESS;
                        tmr_val   = CNT_W'(ACC_CYC - 1);
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_done) begin
                    capture   = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(TA_CYC - 1);
                    state_nxt = ST_RD_RECOVER;
                end
            end
            ST_RD_RECOVER: begin
                if (tmr_done)
                    state_nxt = ST_IDLE;
            end
            ST_WR_TURN: begin
                if (tmr_done) begin
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(DRV_CYC - 1);
                    state_nxt = ST_WR_DRIVE;
                end
            end
            ST_WR_DRIVE: begin
                if (tmr_done)
                    state_nxt = ST_IDLE;
            end
        endcase
    end

    assign lanes_use = accept ? req_lanes : lat_lanes;

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_ce_n   <= '1;
            mem_we_n   <= 1'b1;
            mem_oe_n   <= 1'b1;
            mem_dq_oe  <= 1'b0;
            mem_addr   <= '0;
            mem_dq_out <= '0;
            lat_lanes  <= '0;
            req_ready  <= 1'b1;
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            if (accept) begin
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata;
                lat_lanes  <= req_lanes;
            end
            mem_ce_n  <= (state_nxt == ST_RD_ACCESS || state_nxt == ST_WR_TURN ||
                          state_nxt == ST_WR_DRIVE) ? ~lanes_use : '1;
            mem_we_n  <= !(state_nxt == ST_WR_TURN || state_nxt == ST_WR_DRIVE);
            mem_oe_n  <= !(state_nxt == ST_RD_ACCESS);
            mem_dq_oe <= (state_nxt == ST_WR_DRIVE);
            req_ready <= (state_nxt == ST_IDLE);
            rsp_valid <= capture;
            if (capture)
                rsp_rdata <= cap_data;
        end
    end
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned LANES  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && (&mem_ce_n) && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_read_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> mem_we_n);

    assert_turnaround_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> !mem_dq_oe);

    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> ((&mem_ce_n) && !mem_dq_oe && $past(mem_dq_oe)));

    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_no_contention_R10: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb_top;
    localparam int ACC = 2;
    localparam int TA  = 1;
    localparam int DRV = 1;
    localparam logic [14:0] HI = 15'h7FF3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [23:0] req_wdata = '0;
    logic [2:0]  req_lanes = '0;
    logic        req_ready, rsp_valid, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [23:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [18:0] mem_addr;
    logic [2:0]  mem_ce_n;

    logic [23:0] sram  [16];
    logic [23:0] model [16];
    int checks = 0, errors = 0;
    bit done = 0;
    logic prev_we_n = 1'b1;

    always #4 clk = ~clk;

    sram_lane_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_lanes(req_lanes), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    // Asynchronous RAM model: undriven lanes read as 8'h5A
    always_comb begin
        for (int l = 0; l < 3; l++)
            mem_dq_in[l*8 +: 8] = (!mem_ce_n[l] && mem_we_n && !mem_oe_n)
                                  ? sram[mem_addr[3:0]][l*8 +: 8] : 8'h5A;
    end

    always @(posedge clk) begin
        if (!rst && !mem_we_n && mem_dq_oe)
            for (int l = 0; l < 3; l++)
                if (!mem_ce_n[l]) sram[mem_addr[3:0]][l*8 +: 8] <= mem_dq_out[l*8 +: 8];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] mask_word(input logic [23:0] w, input logic [2:0] m);
        logic [23:0] r;
        for (int l = 0; l < 3; l++) r[l*8 +: 8] = m[l] ? w[l*8 +: 8] : 8'h00;
        return r;
    endfunction

    function automatic logic [23:0] merge_word(input logic [23:0] old, input logic [23:0] nw, input logic [2:0] m);
        logic [23:0] r;
        for (int l = 0; l < 3; l++) r[l*8 +: 8] = m[l] ? nw[l*8 +: 8] : old[l*8 +: 8];
        return r;
    endfunction

    // Per-cycle bus monitors at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe && (mem_we_n || (!mem_oe_n && mem_ce_n != 3'b111)))
                chk(1'b0, "R10 contention", {mem_we_n, mem_oe_n, mem_ce_n}, 32'h0);
            if (mem_dq_oe && prev_we_n)
                chk(1'b0, "R5 drive at strobe fall", 32'(mem_dq_oe), 32'h0);
            prev_we_n = mem_we_n;
        end
    end

    task automatic do_op(input bit w, input logic [3:0] idx, input logic [2:0] lanes,
                         input logic [23:0] data, input bit pester);
        int c;
        bit got_rsp;
        logic [23:0] exp;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = {HI, idx};
        req_wdata = data; req_lanes = lanes;
        exp = mask_word(model[idx], lanes);
        @(negedge clk);
        c = 1; got_rsp = 0;
        if (pester) begin
            req_write = 1'b1; req_addr = {HI, 4'hF}; req_wdata = 24'hDEAD00; req_lanes = 3'b111;
        end else req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8 ready low after accept", 32'(req_ready), 32'h0);
        chk(mem_addr == {HI, idx}, "R6 address", 32'(mem_addr), 32'({HI, idx}));
        while (!req_ready && c < 40) begin
            if (w) begin
                chk(mem_we_n == 1'b0 && mem_ce_n == ~lanes, "R5 write strobe and lanes",
                    {mem_we_n, mem_ce_n}, {1'b0, ~lanes});
                if (c <= TA) chk(mem_dq_oe == 1'b0, "R5 turnaround no drive", 32'(mem_dq_oe), 32'h0);
                else chk(mem_dq_oe == 1'b1 && mem_dq_out == data, "R6 data driven",
                         mem_dq_out, data);
            end else begin
                if (c <= ACC)
                    chk(mem_ce_n == ~lanes && !mem_oe_n && mem_we_n, "R2 read waveform",
                        {mem_we_n, mem_oe_n, mem_ce_n}, {2'b10, ~lanes});
                else
                    chk(mem_ce_n == 3'b111 && mem_oe_n, "R4 recovery released",
                        {mem_oe_n, mem_ce_n}, 4'b1111);
                if (rsp_valid) begin
                    got_rsp = 1;
                    chk(c == ACC + 1, "R3 response cycle", c, ACC + 1);
                    chk(rsp_rdata == exp, lanes == 3'b000 ? "R9 zero-mask read" : "R3 read data",
                        rsp_rdata, exp);
                end
            end
            @(negedge clk);
            c++;
        end
        req_valid = 1'b0;
        if (w) begin
            chk(c == TA + DRV + 1, "R6 write ready return", c, TA + DRV + 1);
            chk(mem_we_n && mem_ce_n == 3'b111 && !mem_dq_oe, "R6 release together",
                {mem_we_n, mem_dq_oe, mem_ce_n}, 5'b10111);
            model[idx] = merge_word(model[idx], data, lanes);
        end else begin
            chk(got_rsp, "R3 response seen", 32'(got_rsp), 32'h1);
            chk(c == ACC + TA + 1, "R4 read ready return", c, ACC + TA + 1);
        end
        chk(sram[idx] == model[idx], "R7 lane isolation", sram[idx], model[idx]);
        chk(sram[15] == model[15], "R8 busy request ignored", sram[15], model[15]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'h1F2E3D);
        for (int i = 0; i < 16; i++) begin
            sram[i]  = 24'($urandom);
            model[i] = sram[i];
        end
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && mem_ce_n == 3'b111 && mem_we_n && mem_oe_n && !mem_dq_oe,
            "R1 reset state", {req_ready, rsp_valid, mem_we_n, mem_oe_n, mem_dq_oe, mem_ce_n},
            8'b10110111);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && mem_ce_n == 3'b111 && !mem_dq_oe, "R1 after reset",
            {req_ready, mem_dq_oe, mem_ce_n}, 5'b10111);

        // Directed corner cases
        do_op(1'b1, 4'd2, 3'b111, 24'hA1B2C3, 1'b0);
        do_op(1'b0, 4'd2, 3'b111, 24'h0, 1'b0);
        do_op(1'b1, 4'd3, 3'b001, 24'h111111, 1'b0);
        do_op(1'b1, 4'd3, 3'b010, 24'h222222, 1'b0);
        do_op(1'b1, 4'd3, 3'b100, 24'h333333, 1'b0);
        do_op(1'b0, 4'd3, 3'b101, 24'h0, 1'b0);
        do_op(1'b0, 4'd3, 3'b000, 24'h0, 1'b0);
        do_op(1'b1, 4'd4, 3'b000, 24'hFFFFFF, 1'b0);
        do_op(1'b0, 4'd4, 3'b111, 24'h0, 1'b0);
        do_op(1'b1, 4'd5, 3'b011, 24'h00BEEF, 1'b1);
        do_op(1'b0, 4'd5, 3'b111, 24'h0, 1'b1);
        do_op(1'b0, 4'd15, 3'b111, 24'h0, 1'b0);

        // Random mix of reads and writes
        for (int n = 0; n < 400; n++)
            do_op(1'($urandom), 4'($urandom_range(0, 14)), 3'($urandom),
                  24'($urandom), 1'($urandom_range(0, 3) == 0));

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule